// File: doc/BRIEF.md
# Multi-Address Serial Slave Bank Decoder

This block is the register-side decoder behind a serial management slave whose transactions are already framed. Each transaction arrives as one strobed cycle carrying the addressed 7-bit slave, a transaction kind, a command byte and up to two data bytes. The decoder answers for one main slave address and for two secondary temperature-sensor slaves. It returns an acknowledge flag and read data one cycle later.

The main address and the sensor addresses are held in configuration registers inside the block. Each sensor slot gets its address from a packed configuration byte: a 3-bit offset above a fixed base, plus a per-slot disable bit. Each sensor slave owns a small bank that holds a read-only measured temperature pair and writable configuration, hysteresis and over-temperature registers. A word command sent to a sensor address becomes a pair of byte accesses into that bank. The two bytes are returned low-register-first in the low byte.

Byte-level traffic reaches a shared register space at the main address. An index pointer, loaded by a send-byte transaction, lets a later receive-byte read a register without a command byte.

Top module: `smb_bank_decoder`

## Requirements
- R1: After reset the main slave address is 0x2D and the slot configuration byte (register 0x4A) is 0x01; it is 0x88 when the parameter SERIAL_EN is 0. In each sensor bank, register 0x53 holds 0x4B, register 0x55 holds 0x50, and 0x52, 0x54 and 0x56 hold 0x00.
- R2: Every cycle with txn_valid high produces exactly one cycle of rsp_valid on the next cycle, and no other cycle does. txn_kind codes: 0 send-byte, 1 receive-byte, 2 write-byte, 3 read-byte, 4 write-word, 5 read-word. Codes 6 and 7 are answered without acknowledge.
- R3: The main slave address is bits [6:0] of register 0x48. Bit 7 of a write is dropped and reads back 0. A new address applies from the next transaction on, and the old address then goes unanswered.
- R4: Sensor slot A answers at 0x48 + config[2:0] unless config[3] is set. Sensor slot B answers at 0x48 + config[6:4] unless config[7] is set. Here config is register 0x4A.
- R5: A transaction to an unmatched or disabled address gets rsp_ack 0 and rsp_data 0. It changes no register and does not change the index.
- R6: A word read at a sensor address picks its target with command bits [1:0]: 0 is the temperature pair 0x50/0x51, 1 is configuration 0x52, 2 is the hysteresis pair 0x53/0x54, and 3 is the over-temperature pair 0x55/0x56.
- R7: A word read returns the first register of the pair in rsp_data[7:0] and the second in rsp_data[15:8]. A configuration word read returns register 0x52 in both bytes.
- R8: A word write at a sensor address stores data[15:8] into the first register of the pair and data[7:0] into the second. A configuration word write stores only data[7:0] into 0x52.
- R9: In each sensor bank, register 0x50 reads the high byte and 0x51 the low byte of that slot's measured temperature input. Byte or word writes to them are ignored.
- R10: A send-byte loads its byte (on txn_cmd) into the index and changes no register. A following receive-byte returns the register at that index in the addressed slave's view.
- R11: A byte access with register number 0x50 to 0x56 at a sensor address reaches that sensor's own bank. Every other byte access reaches the main space. In the main space, 0x48 and 0x4A are read/write, other registers read 0x00, and writes to them are dropped.
- R12: When addresses collide, the main address wins over slot A, and slot A wins over slot B.
- R13: A word read at the main address returns the commanded main-space register in both bytes. A word write there stores data[7:0] into that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_valid | input | 1 | One-cycle transaction strobe |
| txn_kind | input | 3 | Transaction kind code (see R2) |
| txn_addr | input | 7 | Addressed 7-bit slave |
| txn_cmd | input | 8 | Command byte, or the byte of a send-byte |
| txn_wdata | input | 16 | Write data; byte writes use bits [7:0] |
| sns_temp | input | 32 | Measured temperatures, slot A in [15:0], slot B in [31:16] |
| rsp_valid | output | 1 | Response strobe, one cycle after txn_valid |
| rsp_ack | output | 1 | The transaction was accepted by some slave |
| rsp_data | output | 16 | Read data; byte reads in [7:0], upper byte 0 |

## Verification
A bad value in the main address or slot configuration register shows up at the ports on the very next transaction. That transaction gets a missing or wrong acknowledge, or lands in the wrong bank, so the bench retargets addresses through every path, including collisions and disable bits. A corrupted bank cell or index register stays hidden until it is read. For that reason each write is followed soon after by a word read and a byte read of both bytes of the pair, and of the register that the write must leave alone. Responses are compared in order, one cycle after each strobe, so a lost or extra response breaks the rest of the run.

// File: rtl/smb_bank_pkg.sv
package smb_bank_pkg;

  typedef enum logic [2:0] {
    KIND_SEND = 3'd0,
    KIND_RECV = 3'd1,
    KIND_WRB  = 3'd2,
    KIND_RDB  = 3'd3,
    KIND_WRW  = 3'd4,
    KIND_RDW  = 3'd5
  } txn_kind_e;

  // Each sensor slot uses a 4-bit field: 3-bit offset plus disable bit.
  localparam int SLOT_FIELD_W = 4;
  localparam int SLOT_OFS_W   = 3;

  localparam logic [7:0] REG_MAIN_ADDR = 8'h48;
  localparam logic [7:0] REG_SLOT_CFG  = 8'h4A;
  // Bank registers live at 0x50..0x56: upper five bits 01010.
  localparam logic [4:0] BANK_PAGE     = 5'h0A;

  localparam logic [7:0] HYST_RST = 8'h4B;
  localparam logic [7:0] OVER_RST = 8'h50;

  // Bank-local index (low three bits) of the first register of a word pair.
  function automatic logic [2:0] pair_first(input logic [1:0] sel);
    case (sel)
      2'd0:    pair_first = 3'd0;
      2'd1:    pair_first = 3'd2;
      2'd2:    pair_first = 3'd3;
      default: pair_first = 3'd5;
    endcase
  endfunction

  // Bank-local index of the second register; configuration pairs with itself.
  function automatic logic [2:0] pair_second(input logic [1:0] sel);
    case (sel)
      2'd0:    pair_second = 3'd1;
      2'd1:    pair_second = 3'd2;
      2'd2:    pair_second = 3'd4;
      default: pair_second = 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
  parameter int               ADDR_W   = 7,
  parameter int               DATA_W   = 8,
  parameter logic [ADDR_W-1:0] MAIN_RST = 7'h2D,
  parameter logic [DATA_W-1:0] SLOT_RST = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_we,
  input  logic              slot_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              idx_we,
  input  logic [DATA_W-1:0] idx_data,
  output logic [ADDR_W-1:0] main_addr,
  output logic [DATA_W-1:0] slot_cfg,
  output logic [DATA_W-1:0] index
);

  logic [ADDR_W-1:0] main_q, main_d;
  logic [DATA_W-1:0] slot_q, slot_d;
  logic [DATA_W-1:0] idx_q,  idx_d;

  always_comb begin
    main_d = main_q;
    slot_d = slot_q;
    idx_d  = idx_q;
    if (main_we) main_d = wr_data[ADDR_W-1:0];
    if (slot_we) slot_d = wr_data;
    if (idx_we)  idx_d  = idx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= MAIN_RST;
      slot_q <= SLOT_RST;
      idx_q  <= '0;
    end else begin
      if (main_we) main_q <= main_d;
      if (slot_we) slot_q <= slot_d;
      if (idx_we)  idx_q  <= idx_d;
    end
  end

  assign main_addr = main_q;
  assign slot_cfg  = slot_q;
  assign index     = idx_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_we && !slot_we && !idx_we) |=> ($stable(main_q) && $stable(slot_q) && $stable(idx_q))); // R5

endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match
  import smb_bank_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter int                NUM_SNS  = 2,
  parameter logic [ADDR_W-1:0] SNS_BASE = 7'h48
) (
  input  logic [ADDR_W-1:0]              addr,
  input  logic [ADDR_W-1:0]              main_addr,
  input  logic [SLOT_FIELD_W*NUM_SNS-1:0] slot_cfg,
  output logic                           hit_main,
  output logic [NUM_SNS-1:0]             hit_sns
);

  logic [NUM_SNS-1:0] raw_hit;

  for (genvar k = 0; k < NUM_SNS; k++) begin : g_slot
    logic [SLOT_FIELD_W-1:0] field;
    logic [ADDR_W-1:0]       slot_addr;
    assign field     = slot_cfg[k*SLOT_FIELD_W +: SLOT_FIELD_W];
    assign slot_addr = SNS_BASE + ADDR_W'(field[SLOT_OFS_W-1:0]);
    assign raw_hit[k] = !field[SLOT_FIELD_W-1] && (addr == slot_addr);
  end

  assign hit_main = (addr == main_addr);

  // Fixed priority: main, then lower slot numbers.
  always_comb begin
    logic taken;
    taken   = hit_main;
    hit_sns = '0;
    for (int k = 0; k < NUM_SNS; k++) begin
      if (raw_hit[k] && !taken) begin
        hit_sns[k] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/smb_sensor_bank.sv
module smb_sensor_bank
  import smb_bank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*DATA_W-1:0] temp_in,
  input  logic                p0_en,
  input  logic [2:0]          p0_idx,
  input  logic [DATA_W-1:0]   p0_data,
  input  logic                p1_en,
  input  logic [2:0]          p1_idx,
  input  logic [DATA_W-1:0]   p1_data,
  input  logic [2:0]          rd_a_idx,
  input  logic [2:0]          rd_b_idx,
  output logic [DATA_W-1:0]   rd_a_data,
  output logic [DATA_W-1:0]   rd_b_data
);

  // Indices 0 and 1 are the live temperature bytes; 2..6 are stored.
  localparam int FIRST_RW = 2;
  localparam int NSTORE   = 5;

  logic [DATA_W-1:0] store_q [NSTORE];
  logic [DATA_W-1:0] store_d [NSTORE];

  for (genvar e = 0; e < NSTORE; e++) begin : g_cell
    localparam logic [2:0] IDX = 3'(e + FIRST_RW);
    localparam logic [DATA_W-1:0] RST_VAL =
      (IDX == 3'd3) ? DATA_W'(HYST_RST) :
      (IDX == 3'd5) ? DATA_W'(OVER_RST) : '0;

    logic wr_hit;
    assign wr_hit = (p0_en && p0_idx == IDX) || (p1_en && p1_idx == IDX);

    always_comb begin
      store_d[e] = store_q[e];
      if (p1_en && p1_idx == IDX)      store_d[e] = p1_data;
      else if (p0_en && p0_idx == IDX) store_d[e] = p0_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      store_q[e] <= RST_VAL;
      else if (wr_hit) store_q[e] <= store_d[e];
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!p0_en && !p1_en) |=> $stable(store_q[e])); // R5
  end

  function automatic logic [DATA_W-1:0] read_cell(input logic [2:0] idx);
    case (idx)
      3'd0:    read_cell = temp_in[2*DATA_W-1:DATA_W];
      3'd1:    read_cell = temp_in[DATA_W-1:0];
      3'd7:    read_cell = '0;
      default: read_cell = store_q[32'(idx) - FIRST_RW];
    endcase
  endfunction

  assign rd_a_data = read_cell(rd_a_idx);
  assign rd_b_data = read_cell(rd_b_idx);

endmodule

// File: rtl/smb_bank_decoder.sv
module smb_bank_decoder
  import smb_bank_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter bit SERIAL_EN = 1'b1,
  parameter logic [ADDR_W-1:0] MAIN_RST = 7'h2D,
  parameter logic [ADDR_W-1:0] SNS_BASE = 7'h48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txn_valid,
  input  logic [2:0]          txn_kind,
  input  logic [ADDR_W-1:0]   txn_addr,
  input  logic [DATA_W-1:0]   txn_cmd,
  input  logic [2*DATA_W-1:0] txn_wdata,
  input  logic [4*DATA_W-1:0] sns_temp,
  output logic                rsp_valid,
  output logic                rsp_ack,
  output logic [2*DATA_W-1:0] rsp_data
);

  localparam int NUM_SNS = DATA_W / SLOT_FIELD_W;
  localparam int WORD_W  = 2 * DATA_W;
  localparam logic [DATA_W-1:0] SLOT_RST = SERIAL_EN ? DATA_W'(8'h01) : DATA_W'(8'h88);

  // configuration state
  logic [ADDR_W-1:0] main_addr;
  logic [DATA_W-1:0] slot_cfg;
  logic [DATA_W-1:0] index;
  logic              main_we, slot_we, idx_we;
  logic [DATA_W-1:0] cfg_wdata;

  smb_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_RST(MAIN_RST), .SLOT_RST(SLOT_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .main_we(main_we), .slot_we(slot_we), .wr_data(cfg_wdata),
    .idx_we(idx_we), .idx_data(txn_cmd),
    .main_addr(main_addr), .slot_cfg(slot_cfg), .index(index)
  );

  // address decode
  logic               hit_main;
  logic [NUM_SNS-1:0] hit_sns;

  smb_addr_match #(
    .ADDR_W(ADDR_W), .NUM_SNS(NUM_SNS), .SNS_BASE(SNS_BASE)
  ) u_match (
    .addr(txn_addr), .main_addr(main_addr), .slot_cfg(slot_cfg),
    .hit_main(hit_main), .hit_sns(hit_sns)
  );

  // sensor banks
  logic [NUM_SNS-1:0] p0_en, p1_en;
  logic [2:0]         p0_idx, p1_idx, rd_a_idx, rd_b_idx;
  logic [DATA_W-1:0]  p0_data, p1_data;
  logic [DATA_W-1:0]  rd_a_bank [NUM_SNS];
  logic [DATA_W-1:0]  rd_b_bank [NUM_SNS];

  for (genvar k = 0; k < NUM_SNS; k++) begin : g_bank
    smb_sensor_bank #(.DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .temp_in(sns_temp[k*WORD_W +: WORD_W]),
      .p0_en(p0_en[k]), .p0_idx(p0_idx), .p0_data(p0_data),
      .p1_en(p1_en[k]), .p1_idx(p1_idx), .p1_data(p1_data),
      .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
      .rd_a_data(rd_a_bank[k]), .rd_b_data(rd_b_bank[k])
    );
  end

  // read mux of the selected bank
  logic [DATA_W-1:0] sel_a, sel_b;
  always_comb begin
    sel_a = '0;
    sel_b = '0;
    for (int k = 0; k < NUM_SNS; k++) begin
      if (hit_sns[k]) begin
        sel_a = sel_a | rd_a_bank[k];
        sel_b = sel_b | rd_b_bank[k];
      end
    end
  end

  // register number and main-space read
  txn_kind_e         kind;
  logic [DATA_W-1:0] reg_sel;
  logic              in_bank;
  logic              sns_hit;
  logic              hit_any;
  logic [DATA_W-1:0] main_rd;

  assign kind    = txn_kind_e'(txn_kind);
  assign reg_sel = (kind == KIND_RECV) ? index : txn_cmd;
  assign in_bank = (reg_sel[DATA_W-1:3] == (DATA_W-3)'(BANK_PAGE)) && (reg_sel[2:0] != 3'd7);
  assign sns_hit = |hit_sns;
  assign hit_any = hit_main || sns_hit;

  always_comb begin
    if (reg_sel == DATA_W'(REG_MAIN_ADDR))     main_rd = DATA_W'(main_addr);
    else if (reg_sel == DATA_W'(REG_SLOT_CFG)) main_rd = slot_cfg;
    else                                       main_rd = '0;
  end

  // next-state of the transaction
  logic              rsp_valid_q, rsp_ack_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic              ack_d;
  logic [WORD_W-1:0] data_d;
  logic              main_space_we;

  always_comb begin
    ack_d         = 1'b0;
    data_d        = '0;
    idx_we        = 1'b0;
    main_space_we = 1'b0;
    cfg_wdata     = txn_wdata[DATA_W-1:0];
    p0_en         = '0;
    p1_en         = '0;
    p0_idx        = reg_sel[2:0];
    p1_idx        = reg_sel[2:0];
    p0_data       = txn_wdata[DATA_W-1:0];
    p1_data       = txn_wdata[DATA_W-1:0];
    rd_a_idx      = reg_sel[2:0];
    rd_b_idx      = reg_sel[2:0];
    if (txn_valid && hit_any) begin
      unique case (kind)
        KIND_SEND: begin
          ack_d  = 1'b1;
          idx_we = 1'b1;
        end
        KIND_RECV, KIND_RDB: begin
          ack_d = 1'b1;
          if (sns_hit && in_bank) data_d = WORD_W'(sel_a);
          else                    data_d = WORD_W'(main_rd);
        end
        KIND_WRB: begin
          ack_d = 1'b1;
          if (sns_hit && in_bank) p0_en = hit_sns;
          else                    main_space_we = 1'b1;
        end
        KIND_RDW: begin
          ack_d = 1'b1;
          if (sns_hit) begin
            rd_a_idx = pair_first(txn_cmd[1:0]);
            rd_b_idx = pair_second(txn_cmd[1:0]);
            data_d   = {sel_b, sel_a};
          end else begin
            data_d   = {main_rd, main_rd};
          end
        end
        KIND_WRW: begin
          ack_d = 1'b1;
          if (sns_hit) begin
            if (txn_cmd[1:0] == 2'd1) begin
              p0_idx = 3'd2;
              p0_en  = hit_sns;
            end else begin
              p0_idx  = pair_first(txn_cmd[1:0]);
              p0_data = txn_wdata[WORD_W-1:DATA_W];
              p1_idx  = pair_second(txn_cmd[1:0]);
              p0_en   = hit_sns;
              p1_en   = hit_sns;
            end
          end else begin
            main_space_we = 1'b1;
          end
        end
        default: ack_d = 1'b0;
      endcase
    end
  end

  assign main_we = main_space_we && (reg_sel == DATA_W'(REG_MAIN_ADDR));
  assign slot_we = main_space_we && (reg_sel == DATA_W'(REG_SLOT_CFG));

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_ack_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= txn_valid;
      if (txn_valid) begin
        rsp_ack_q  <= ack_d;
        rsp_data_q <= data_d;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ack   = rsp_ack_q;
  assign rsp_data  = rsp_data_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> rsp_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !rsp_valid); // R2
  AST_NACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |-> (rsp_data == '0)); // R5
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !hit_any) |=> ($stable(main_addr) && $stable(slot_cfg) && $stable(index))); // R5

endmodule

// File: tb/sim_smb_bank_decoder.sv
module sim_smb_bank_decoder;
  import smb_bank_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        txn_valid;
  logic [2:0]  txn_kind;
  logic [6:0]  txn_addr;
  logic [7:0]  txn_cmd;
  logic [15:0] txn_wdata;
  logic [31:0] sns_temp;
  logic        rsp_valid;
  logic        rsp_ack;
  logic [15:0] rsp_data;

  int checks = 0;
  int errors = 0;
  logic [16:0] exp_q [$];
  string       tag_q [$];

  smb_bank_decoder u0 (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_kind(txn_kind),
    .txn_addr(txn_addr), .txn_cmd(txn_cmd), .txn_wdata(txn_wdata),
    .sns_temp(sns_temp), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2: actual=hung expected=done");
    finish_run();
  end

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response: actual=%0b_%04h expected=none", rsp_ack, rsp_data);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_ack, rsp_data} !== e)
          begin
            errors++;
            $display("FAIL %s: actual=%0b_%04h expected=%0b_%04h", t, rsp_ack, rsp_data, e[16], e[15:0]);
          end
      end
    end
  end

  // driver: one transaction per cycle, expected result queued
  task automatic txn(input logic [2:0] k, input logic [6:0] a, input logic [7:0] c,
                     input logic [15:0] w, input logic ea, input logic [15:0] ed, input string t);
    @(negedge clk);
    txn_valid = 1'b1;
    txn_kind  = k;
    txn_addr  = a;
    txn_cmd   = c;
    txn_wdata = w;
    exp_q.push_back({ea, ed});
    tag_q.push_back(t);
  endtask

  task automatic idle_check(input string t);
    @(negedge clk);
    txn_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: actual=%0b expected=0", t, rsp_valid);
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    txn_valid = 1'b0;
    txn_kind  = '0;
    txn_addr  = '0;
    txn_cmd   = '0;
    txn_wdata = '0;
    sns_temp  = {16'h2300, 16'h1A80};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 reset: actual=%0b expected=0", rsp_valid);
    end

    // reset state: A at 0x49, B at 0x48
    txn(KIND_RDB, 7'h2D, 8'h48, 16'h0, 1'b1, 16'h002D, "R1 main address");
    txn(KIND_RDB, 7'h2D, 8'h4A, 16'h0, 1'b1, 16'h0001, "R1 slot config");
    txn(KIND_RDW, 7'h49, 8'h02, 16'h0, 1'b1, 16'h004B, "R1 R6 hysteresis pair A");
    txn(KIND_RDW, 7'h48, 8'h03, 16'h0, 1'b1, 16'h0050, "R1 R6 over-temp pair B");
    txn(KIND_RDW, 7'h48, 8'h01, 16'h0, 1'b1, 16'h0000, "R1 config B");
    txn(KIND_RDW, 7'h49, 8'h00, 16'h0, 1'b1, 16'h801A, "R7 R9 temp pair A");
    txn(KIND_RDW, 7'h48, 8'h00, 16'h0, 1'b1, 16'h0023, "R9 temp pair B");

    // word write and byte order
    txn(KIND_WRW, 7'h49, 8'h03, 16'h6A05, 1'b1, 16'h0000, "R8 word write ack");
    txn(KIND_RDW, 7'h49, 8'h03, 16'h0, 1'b1, 16'h056A, "R8 word readback");
    txn(KIND_RDB, 7'h49, 8'h55, 16'h0, 1'b1, 16'h006A, "R8 R11 first byte");
    txn(KIND_RDB, 7'h49, 8'h56, 16'h0, 1'b1, 16'h0005, "R8 R11 second byte");
    txn(KIND_RDB, 7'h48, 8'h55, 16'h0, 1'b1, 16'h0050, "R11 bank B separate");
    txn(KIND_WRW, 7'h49, 8'h01, 16'h77C3, 1'b1, 16'h0000, "R8 config write");
    txn(KIND_RDW, 7'h49, 8'h01, 16'h0, 1'b1, 16'hC3C3, "R7 config both bytes");
    txn(KIND_RDB, 7'h49, 8'h52, 16'h0, 1'b1, 16'h00C3, "R8 config low byte only");
    txn(KIND_RDB, 7'h49, 8'h53, 16'h0, 1'b1, 16'h004B, "R8 config write leaves neighbour");

    // read-only temperature
    txn(KIND_WRW, 7'h49, 8'h00, 16'h1234, 1'b1, 16'h0000, "R9 word write to temp");
    txn(KIND_RDW, 7'h49, 8'h00, 16'h0, 1'b1, 16'h801A, "R9 temp unchanged");
    txn(KIND_WRB, 7'h49, 8'h50, 16'h0099, 1'b1, 16'h0000, "R9 byte write to temp");
    txn(KIND_RDB, 7'h49, 8'h50, 16'h0, 1'b1, 16'h001A, "R9 temp high byte");
    txn(KIND_WRB, 7'h49, 8'h54, 16'h003C, 1'b1, 16'h0000, "R11 byte write bank");
    txn(KIND_RDW, 7'h49, 8'h02, 16'h0, 1'b1, 16'h3C4B, "R11 R7 hysteresis pair");

    // unmatched address
    txn(KIND_RDB, 7'h30, 8'h48, 16'h0, 1'b0, 16'h0000, "R5 miss read");
    txn(KIND_WRB, 7'h30, 8'h4A, 16'h0088, 1'b0, 16'h0000, "R5 miss write");
    txn(KIND_RDB, 7'h2D, 8'h4A, 16'h0, 1'b1, 16'h0001, "R5 config untouched");

    // index
    txn(KIND_SEND, 7'h2D, 8'h4A, 16'h0, 1'b1, 16'h0000, "R10 send ack");
    txn(KIND_SEND, 7'h30, 8'h48, 16'h0, 1'b0, 16'h0000, "R5 miss send");
    txn(KIND_RECV, 7'h2D, 8'h00, 16'h0, 1'b1, 16'h0001, "R5 R10 index kept");
    txn(KIND_SEND, 7'h49, 8'h53, 16'h0, 1'b1, 16'h0000, "R10 send at sensor");
    txn(KIND_RECV, 7'h49, 8'h00, 16'h0, 1'b1, 16'h004B, "R10 receive A");
    txn(KIND_RECV, 7'h48, 8'h00, 16'h0, 1'b1, 16'h004B, "R10 receive B");
    txn(KIND_RDB, 7'h2D, 8'h48, 16'h0, 1'b1, 16'h002D, "R10 send wrote nothing");

    // main space cannot reach a bank
    txn(KIND_WRB, 7'h2D, 8'h55, 16'h0077, 1'b1, 16'h0000, "R11 main write 0x55");
    txn(KIND_RDB, 7'h49, 8'h55, 16'h0, 1'b1, 16'h006A, "R11 bank untouched");
    txn(KIND_RDB, 7'h2D, 8'h55, 16'h0, 1'b1, 16'h0000, "R11 main reads zero");

    // word at main address, retarget slots
    txn(KIND_RDW, 7'h2D, 8'h48, 16'h0, 1'b1, 16'h2D2D, "R13 word read main");
    txn(KIND_WRW, 7'h2D, 8'h4A, 16'hAB23, 1'b1, 16'h0000, "R13 word write main");
    txn(KIND_RDB, 7'h2D, 8'h4A, 16'h0, 1'b1, 16'h0023, "R13 low byte stored");
    txn(KIND_RDB, 7'h4B, 8'h55, 16'h0, 1'b1, 16'h006A, "R4 slot A moved");
    txn(KIND_RDB, 7'h4A, 8'h55, 16'h0, 1'b1, 16'h0050, "R4 slot B moved");
    txn(KIND_RDB, 7'h49, 8'h55, 16'h0, 1'b0, 16'h0000, "R4 old address silent");

    // disable bits
    txn(KIND_WRB, 7'h2D, 8'h4A, 16'h00AB, 1'b1, 16'h0000, "R4 disable both");
    txn(KIND_RDB, 7'h4B, 8'h55, 16'h0, 1'b0, 16'h0000, "R4 A disabled");
    txn(KIND_RDB, 7'h4A, 8'h55, 16'h0, 1'b0, 16'h0000, "R4 B disabled");
    txn(KIND_WRB, 7'h2D, 8'h4A, 16'h002B, 1'b1, 16'h0000, "R4 enable B only");
    txn(KIND_RDB, 7'h4A, 8'h55, 16'h0, 1'b1, 16'h0050, "R4 B enabled");
    txn(KIND_RDB, 7'h4B, 8'h55, 16'h0, 1'b0, 16'h0000, "R4 A still disabled");
    txn(KIND_WRB, 7'h4B, 8'h54, 16'h00EE, 1'b0, 16'h0000, "R5 write at disabled");

    // main address change and priority
    txn(KIND_WRB, 7'h2D, 8'h48, 16'h004A, 1'b1, 16'h0000, "R3 move main");
    txn(KIND_RDB, 7'h2D, 8'h48, 16'h0, 1'b0, 16'h0000, "R3 old main silent");
    txn(KIND_RDB, 7'h4A, 8'h48, 16'h0, 1'b1, 16'h004A, "R3 new main");
    txn(KIND_RDB, 7'h4A, 8'h55, 16'h0, 1'b1, 16'h0000, "R12 main over B");
    txn(KIND_WRB, 7'h4A, 8'h4A, 16'h0033, 1'b1, 16'h0000, "R12 collide A and B");
    txn(KIND_RDB, 7'h4B, 8'h55, 16'h0, 1'b1, 16'h006A, "R12 A over B");
    txn(KIND_RDB, 7'h4B, 8'h54, 16'h0, 1'b1, 16'h003C, "R5 disabled write dropped");
    txn(KIND_WRB, 7'h4A, 8'h48, 16'h00AD, 1'b1, 16'h0000, "R3 write bit7 set");
    txn(KIND_RDB, 7'h2D, 8'h48, 16'h0, 1'b1, 16'h002D, "R3 bit7 dropped");
    txn(3'd6, 7'h2D, 8'h48, 16'h0, 1'b0, 16'h0000, "R2 unused kind");
    idle_check("R2");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses: actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end

endmodule